// File: doc/BRIEF.md
# DRAM Power-Up and CAS-First Refresh Sequencer

This block owns the start-up and row-retention housekeeping of an asynchronous EDO DRAM. After reset it holds every DRAM control strobe inactive for a programmable pause, then runs a fixed burst of CAS-before-RAS refresh cycles on its own. Once that burst completes it raises an init-complete flag, and the access controller may begin normal traffic.

In normal operation an interval timer adds one owed refresh every `REF_INTERVAL_CYC` clocks. The interval is chosen so that every row is refreshed within the retention period; for example, 64 ms spread over 4096 rows gives about 15.6 us. Owed refreshes collect in a small backlog counter. While the sequencer is idle and the backlog is non-zero, it raises a request toward the access controller. The request becomes urgent when the backlog is full. When the controller grants, the sequencer drives one CAS-before-RAS cycle and returns a one-clock done pulse. No address is driven, because the DRAM's internal row counter picks the row. Write-enable and output-enable are held high at all times, so the parallel test mode can never be entered by accident.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset until `PWRUP_CYC` clocks after reset release, RAS, both CAS strobes, WE and OE are high, and `ref_req`, `ref_urgent`, `ref_done` and `init_done` are low. The first CAS fall is seen `PWRUP_CYC + T_RPC` clocks after reset release.
- R2: After the pause, exactly `INIT_CYCLES` refresh cycles run back to back without any grant. `init_done` rises `PWRUP_CYC + INIT_CYCLES*L` clocks after reset release and stays high, where L = `T_RPC + T_CSR + max(T_RAS,T_CHR) + T_RP`.
- R3: In every refresh cycle both CAS strobes fall together, `T_CSR` clocks before RAS falls. CAS and RAS then stay low together for `max(T_RAS,T_CHR)` clocks, and all three rise on the same clock. The two CAS strobes never differ.
- R4: WE and OE are high in every clock cycle.
- R5: CAS falls only while RAS is high. A CAS fall comes at least `T_RP + T_RPC` clocks after the previous RAS rise.
- R6: Starting from the clock where `init_done` rises, the interval timer adds one owed refresh every `REF_INTERVAL_CYC` clocks. The first `ref_req` is seen exactly `REF_INTERVAL_CYC` clocks after `init_done` rises.
- R7: The backlog grows with each interval and saturates at `BACKLOG_MAX`. `ref_urgent` is high exactly while the backlog equals `BACKLOG_MAX`. A saturated backlog is drained by exactly `BACKLOG_MAX` granted cycles.
- R8: A grant sampled while `ref_req` is high starts a cycle on that clock edge. `ref_req` is low on the following clock, CAS falls `T_RPC` clocks after the start, and `ref_done` pulses for one clock, `L` clocks after the start and `T_RP` clocks after RAS rises.
- R9: A grant while `ref_req` is low, during start-up or with an empty backlog, starts no cycle and leaves RAS high.
- R10: `ref_done` never pulses before `init_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_grant | input | 1 | Access controller hands the DRAM to the sequencer |
| ref_req | output | 1 | A refresh is owed and the sequencer is idle |
| ref_urgent | output | 1 | Backlog of owed refreshes is full |
| ref_done | output | 1 | One-clock pulse when a granted refresh has finished |
| init_done | output | 1 | Power-up pause and initial refresh burst are complete |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Lower and upper byte column strobes, active low |
| dram_we_n | output | 1 | Write enable, held high |
| dram_oe_n | output | 1 | Output enable, held high |

## Verification
The hardest state to reach is a full backlog followed by a drain that must finish before the next interval tick. The bench withholds grants for several intervals so the counter reaches saturation and extra ticks are discarded. It then grants continuously, starting one clock after a tick, and counts done pulses up to the clock before the next tick. Grants issued during the pause and in the empty window after start-up show that a grant alone starts nothing.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP = 3'd0,
    ST_IDLE  = 3'd1,
    ST_PRE   = 3'd2,
    ST_CAS   = 3'd3,
    ST_RAS   = 3'd4,
    ST_RP    = 3'd5
  } drs_state_e;

  function automatic int drs_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drs_interval.sv
module drs_interval #(
  parameter int REF_INTERVAL_CYC = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);

  localparam int TW = $clog2(REF_INTERVAL_CYC + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = en_i && (cnt_q == '0);
    cnt_d  = cnt_q;
    if (!en_i) begin
      cnt_d = TW'(REF_INTERVAL_CYC - 1);
    end else if (cnt_q == '0) begin
      cnt_d = TW'(REF_INTERVAL_CYC - 1);
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= TW'(REF_INTERVAL_CYC - 1);
    else        cnt_q <= cnt_d;
  end

  assert_tick_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/drs_backlog.sv
module drs_backlog #(
  parameter int BACKLOG_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic take_i,
  output logic pend_nz_o,
  output logic urgent_o
);

  localparam int PW = $clog2(BACKLOG_MAX + 1);

  logic [PW-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (tick_i && !take_i) begin
      if (pend_q != PW'(BACKLOG_MAX)) pend_d = pend_q + 1'b1;
    end else if (take_i && !tick_i) begin
      pend_d = pend_q - 1'b1;
    end
    pend_nz_o = (pend_q != '0);
    urgent_o  = (pend_q == PW'(BACKLOG_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assert_backlog_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PW'(BACKLOG_MAX));

  assert_urgent_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent_o && tick_i && !take_i) |=> urgent_o);

  assert_no_take_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> pend_nz_o);

endmodule

// File: rtl/drs_cbr_fsm.sv
module drs_cbr_fsm
  import drs_pkg::*;
#(
  parameter int PWRUP_CYC   = 20000,
  parameter int INIT_CYCLES = 8,
  parameter int T_RPC       = 1,
  parameter int T_CSR       = 1,
  parameter int T_LOW       = 5,
  parameter int T_RP        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic idle_o,
  output logic init_done_o,
  output logic done_o
);

  localparam int CMAX = drs_max(drs_max(PWRUP_CYC, T_RPC), drs_max(drs_max(T_CSR, T_LOW), T_RP));
  localparam int CW   = $clog2(CMAX + 1);
  localparam int IW   = $clog2(INIT_CYCLES + 1);

  drs_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] init_cnt_q, init_cnt_d;
  logic          init_done_q, init_done_d;
  logic          done_q, done_d;
  logic          ras_q, ras_d;
  logic          cas_q, cas_d;
  logic          last;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    init_cnt_d  = init_cnt_q;
    init_done_d = init_done_q;
    done_d      = 1'b0;
    last        = (cnt_q == '0);
    case (state_q)
      ST_PWRUP: begin
        if (last) begin
          state_d = ST_PRE;
          cnt_d   = CW'(T_RPC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_PRE;
          cnt_d   = CW'(T_RPC - 1);
        end
      end
      ST_PRE: begin
        if (last) begin
          state_d = ST_CAS;
          cnt_d   = CW'(T_CSR - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_CAS: begin
        if (last) begin
          state_d = ST_RAS;
          cnt_d   = CW'(T_LOW - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RAS: begin
        if (last) begin
          state_d = ST_RP;
          cnt_d   = CW'(T_RP - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RP: begin
        if (!last) begin
          cnt_d = cnt_q - 1'b1;
        end else if (init_done_q) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (init_cnt_q == IW'(INIT_CYCLES - 1)) begin
          init_done_d = 1'b1;
          state_d     = ST_IDLE;
        end else begin
          init_cnt_d = init_cnt_q + 1'b1;
          state_d    = ST_PRE;
          cnt_d      = CW'(T_RPC - 1);
        end
      end
      default: begin
        state_d = ST_PWRUP;
        cnt_d   = '0;
      end
    endcase
    ras_d = (state_d != ST_RAS);
    cas_d = !((state_d == ST_CAS) || (state_d == ST_RAS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_PWRUP;
      cnt_q       <= CW'(PWRUP_CYC - 1);
      init_cnt_q  <= '0;
      init_done_q <= 1'b0;
      done_q      <= 1'b0;
      ras_q       <= 1'b1;
      cas_q       <= 1'b1;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      init_cnt_q  <= init_cnt_d;
      init_done_q <= init_done_d;
      done_q      <= done_d;
      ras_q       <= ras_d;
      cas_q       <= cas_d;
    end
  end

  assign ras_n_o     = ras_q;
  assign cas_n_o     = cas_q;
  assign idle_o      = (state_q == ST_IDLE);
  assign init_done_o = init_done_q;
  assign done_o      = done_q;

  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_q) |-> (!cas_q && $past(!cas_q)));

  assert_strobes_rise_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_q) |-> cas_q);

  assert_cas_falls_ras_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_q) |-> (ras_q && $past(ras_q)));

  assert_no_done_in_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done_q |-> !done_q);

  assert_init_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_q |=> init_done_q);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drs_pkg::*;
#(
  parameter int PWRUP_CYC        = 20000,
  parameter int INIT_CYCLES      = 8,
  parameter int REF_INTERVAL_CYC = 1562,
  parameter int BACKLOG_MAX      = 8,
  parameter int T_RPC            = 1,
  parameter int T_CSR            = 1,
  parameter int T_RAS            = 5,
  parameter int T_CHR            = 1,
  parameter int T_RP             = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_grant,
  output logic       ref_req,
  output logic       ref_urgent,
  output logic       ref_done,
  output logic       init_done,
  output logic       dram_ras_n,
  output logic [1:0] dram_cas_n,
  output logic       dram_we_n,
  output logic       dram_oe_n
);

  localparam int T_LOW = drs_max(T_RAS, T_CHR);

  logic tick;
  logic start;
  logic pend_nz;
  logic idle;
  logic cas_n;

  drs_interval #(
    .REF_INTERVAL_CYC(REF_INTERVAL_CYC)
  ) u_interval (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (init_done),
    .tick_o(tick)
  );

  drs_backlog #(
    .BACKLOG_MAX(BACKLOG_MAX)
  ) u_backlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .take_i   (start),
    .pend_nz_o(pend_nz),
    .urgent_o (ref_urgent)
  );

  drs_cbr_fsm #(
    .PWRUP_CYC  (PWRUP_CYC),
    .INIT_CYCLES(INIT_CYCLES),
    .T_RPC      (T_RPC),
    .T_CSR      (T_CSR),
    .T_LOW      (T_LOW),
    .T_RP       (T_RP)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .ras_n_o    (dram_ras_n),
    .cas_n_o    (cas_n),
    .idle_o     (idle),
    .init_done_o(init_done),
    .done_o     (ref_done)
  );

  assign ref_req    = init_done && idle && pend_nz;
  assign start      = ref_req && ref_grant;
  assign dram_cas_n = {2{cas_n}};
  assign dram_we_n  = 1'b1;
  assign dram_oe_n  = 1'b1;

  assert_req_drops_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ref_req);

  assert_ras_low_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start) |=> dram_ras_n);

endmodule

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;

  localparam int CLK_PERIOD  = 10;
  localparam int PWRUP       = 20;
  localparam int INIT_N      = 4;
  localparam int INTERVAL    = 40;
  localparam int BACKLOG     = 3;
  localparam int T_RPC       = 1;
  localparam int T_CSR       = 2;
  localparam int T_RAS       = 4;
  localparam int T_CHR       = 2;
  localparam int T_RP        = 3;
  localparam int T_LOW       = (T_RAS > T_CHR) ? T_RAS : T_CHR;
  localparam int L           = T_RPC + T_CSR + T_LOW + T_RP;

  logic       clk;
  logic       rst_n;
  logic       ref_grant;
  logic       ref_req, ref_urgent, ref_done, init_done;
  logic       dram_ras_n, dram_we_n, dram_oe_n;
  logic [1:0] dram_cas_n;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int ras_falls = 0, init_falls = 0, done_cnt = 0;
  int cf = -1, rf = -1, rr = -1;
  bit first_cas = 1'b1;
  bit we_bad = 1'b0, split_bad = 1'b0;
  bit finished = 1'b0;
  logic prev_ras, prev_cas;

  dram_refresh_seq #(
    .PWRUP_CYC(PWRUP), .INIT_CYCLES(INIT_N), .REF_INTERVAL_CYC(INTERVAL),
    .BACKLOG_MAX(BACKLOG), .T_RPC(T_RPC), .T_CSR(T_CSR), .T_RAS(T_RAS),
    .T_CHR(T_CHR), .T_RP(T_RP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .ref_done(ref_done), .init_done(init_done),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cyc %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // strobe shape monitor, sampled on the falling clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (dram_we_n !== 1'b1 || dram_oe_n !== 1'b1) we_bad = 1'b1;
      if (dram_cas_n[0] !== dram_cas_n[1]) split_bad = 1'b1;
      if (prev_cas && !dram_cas_n[0]) begin
        check(dram_ras_n == 1'b1, "R5 ras high at cas fall", int'(dram_ras_n), 1);
        if (first_cas) begin
          check(cyc == PWRUP + T_RPC, "R1 first cas fall", cyc, PWRUP + T_RPC);
          first_cas = 1'b0;
        end else begin
          check(cyc - rr >= T_RP + T_RPC, "R5 ras precharge gap", cyc - rr, T_RP + T_RPC);
        end
        cf = cyc;
      end
      if (prev_ras && !dram_ras_n) begin
        check(cyc - cf == T_CSR, "R3 cas lead", cyc - cf, T_CSR);
        check(dram_cas_n == 2'b00, "R3 cas low at ras fall", int'(dram_cas_n), 0);
        ras_falls++;
        if (!init_done) init_falls++;
        rf = cyc;
      end
      if (!prev_ras && dram_ras_n) begin
        check(cyc - rf == T_LOW, "R3 low phase", cyc - rf, T_LOW);
        check(dram_cas_n == 2'b11, "R3 rise together", int'(dram_cas_n), 3);
        rr = cyc;
      end
      if (ref_done) begin
        done_cnt++;
        check(init_done == 1'b1, "R10 done after init", int'(init_done), 1);
        check(cyc - rr == T_RP, "R8 done after precharge", cyc - rr, T_RP);
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n[0];
    end else begin
      prev_ras = 1'b1;
      prev_cas = 1'b1;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired at cyc %0d: actual 0 expected 1", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int i0;
    int d0;
    rst_n     = 1'b0;
    ref_grant = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 5'b11111, "R1 strobes in reset",
          int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 31);
    check({ref_req, ref_urgent, ref_done, init_done} == 4'b0000, "R1 outputs in reset",
          int'({ref_req, ref_urgent, ref_done, init_done}), 0);
    rst_n = 1'b1;
    // R1: pause holds strobes high, R9 grant ignored during pause
    wait_cyc(PWRUP + T_RPC - 1);
    check(dram_cas_n == 2'b11 && dram_ras_n && !ref_req, "R1 pause quiet",
          int'({dram_ras_n, dram_cas_n, ref_req}), 14);
    // R2: initial burst
    while (!init_done) @(negedge clk);
    i0 = cyc;
    check(i0 == PWRUP + INIT_N * L, "R2 init_done time", i0, PWRUP + INIT_N * L);
    check(init_falls == INIT_N, "R2 init cycle count", init_falls, INIT_N);
    check(done_cnt == 0, "R10 no done in init", done_cnt, 0);
    // R9: grant with empty backlog has no effect
    wait_cyc(i0 + 20);
    check(ras_falls == INIT_N && dram_ras_n && !ref_done, "R9 grant without req", ras_falls, INIT_N);
    ref_grant = 1'b0;
    // R6: first request
    while (!ref_req) @(negedge clk);
    check(cyc == i0 + INTERVAL, "R6 first request", cyc - i0, INTERVAL);
    check(!ref_urgent, "R7 not urgent at one", int'(ref_urgent), 0);
    wait_cyc(i0 + 2 * INTERVAL);
    check(ref_req && !ref_urgent, "R6 second tick not urgent", int'(ref_urgent), 0);
    // R7: urgent at saturation
    while (!ref_urgent) @(negedge clk);
    check(cyc == i0 + BACKLOG * INTERVAL, "R7 urgent time", cyc - i0, BACKLOG * INTERVAL);
    wait_cyc(i0 + 5 * INTERVAL + 1);
    check(ref_urgent && ref_req, "R7 still saturated", int'(ref_urgent), 1);
    d0 = done_cnt;
    ref_grant = 1'b1;
    @(negedge clk);
    check(!ref_req, "R8 req drops after grant", int'(ref_req), 0);
    check(!ref_urgent, "R7 urgent clears after take", int'(ref_urgent), 0);
    wait_cyc(i0 + 5 * INTERVAL + 2 + T_RPC);
    check(dram_cas_n == 2'b00, "R8 cas fall after start", int'(dram_cas_n), 0);
    wait_cyc(i0 + 6 * INTERVAL - 1);
    check(done_cnt - d0 == BACKLOG, "R7 drain count", done_cnt - d0, BACKLOG);
    check(!ref_req && !ref_urgent, "R7 backlog empty", int'({ref_req, ref_urgent}), 0);
    // R8/R6: steady single refresh
    d0 = done_cnt;
    while (!ref_done) @(negedge clk);
    check(cyc == i0 + 6 * INTERVAL + 1 + L, "R8 done timing", cyc - i0, 6 * INTERVAL + 1 + L);
    @(negedge clk);
    check(!ref_done, "R8 done one clock", int'(ref_done), 0);
    check(done_cnt - d0 == 1, "R8 single refresh", done_cnt - d0, 1);
    // R4/R3: whole-run strobe properties
    check(!we_bad, "R4 we oe high", int'(we_bad), 0);
    check(!split_bad, "R3 cas pair equal", int'(split_bad), 0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule